// File: doc/BRIEF.md
# Counter-Based Contact Debouncer

This block turns a noisy single-bit input, such as a mechanical switch or one contact of a rotary encoder, into a clean level. The raw input passes through a two-register synchronizer. Any difference between the two stages marks a transition and restarts a stability timer. The timer climbs while the synchronized level holds and stops once it is all ones. Only while the timer sits at that ceiling does the output register copy the synchronized level. Bounce bursts shorter than the timer span never reach the output.

The timer width `TIMER_W` sets the filter window. Each extra bit doubles the required quiet time. For example, 16 bits at a 50 MHz clock need about 1.3 ms of steady input, and 12 bits need only about 80 µs. The whole block runs in one clock domain with a synchronous, active-high reset. The output register is a clock-enabled flop and is never clocked by the timer.

In the requirements, M = 2^TIMER_W - 1. "Edge #1" is the first rising clock edge at which a new input level is sampled.

Top module: `debounce_filter`

## Requirements
- R1: If a new input level is held, the output takes that level on exactly edge #(M+3). At edge #(M+2) the output still shows the old level.
- R2: A change of the synchronized input restarts the stability timer from zero, so the full M+3 edge window counts again from the last transition.
- R3: While the synchronized input is steady, the timer advances by one per clock. It then stays at all ones, and the output stays unchanged, for as long as the input holds.
- R4: The output changes only on an edge that follows a cycle in which the timer was all ones. It then takes the second synchronizer stage's value.
- R5: An input pulse that lasts M clock cycles or fewer, or any burst of such pulses, leaves the output unchanged.
- R6: An input pulse that lasts exactly M+1 cycles reaches the output on its edge #(M+3). At that edge the timer clear and the output load happen together.
- R7: While `rst` is high at a rising edge, the output and both synchronizer stages take `RESET_LEVEL` (default 0), and the timer is set to all ones.
- R8: If the input differs from `RESET_LEVEL` when reset is released, the output needs the full window. It changes on edge #(M+3), counted from the first edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rawIn | input | 1 | Noisy input level |
| cleanOut | output | 1 | Debounced level |

## Verification
A timer clear and an output load fall in the same cycle when an input pulse ends at the exact moment the timer reaches its ceiling. The bench provokes this with a pulse of exactly M+1 cycles. It expects the pulse level to appear on the output one edge later than the return edge, and the return level to need a further full window. A pulse of M cycles sits next to it as the case that must be absorbed. The two outcomes are judged at the exact edges that the requirements predict.

// File: rtl/dbn_pkg.sv
`timescale 1ns/1ps
package dbn_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic timerClear;  // restart stability timer
    logic timerStep;   // advance stability timer
    logic outLoad;     // copy synchronized level to output
  } dbnStrobes_t;

endpackage

// File: rtl/dbn_control.sv
`timescale 1ns/1ps
module dbn_control
  import dbn_pkg::*;
(
  input  logic        sampleChange,
  input  logic        timerFull,
  output dbnStrobes_t strobes
);

  // A transition wins over counting; a full timer stops counting and
  // opens the output register.
  always_comb begin
    strobes.timerClear = sampleChange;
    strobes.timerStep  = !sampleChange && !timerFull;
    strobes.outLoad    = timerFull;
  end

endmodule

// File: rtl/dbn_datapath.sv
`timescale 1ns/1ps
module dbn_datapath
  import dbn_pkg::*;
#(
  parameter int   TIMER_W     = 16,
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rawIn,
  input  dbnStrobes_t strobes,
  output logic        sampleChange,
  output logic        timerFull,
  output logic        cleanOut
);

  localparam logic [TIMER_W-1:0] TIMER_MAX = {TIMER_W{1'b1}};
  localparam logic [TIMER_W-1:0] TIMER_ONE = TIMER_W'(1);

  logic               syncA;
  logic               syncB;
  logic [TIMER_W-1:0] timer;
  logic               pastValid;

  // Two-stage sampler
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= RESET_LEVEL;
      syncB <= RESET_LEVEL;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
    end
  end

  assign sampleChange = syncA ^ syncB;
  assign timerFull    = (timer == TIMER_MAX);

  // Stability timer, saturated at reset
  always_ff @(posedge clk) begin
    if (rst)                    timer <= TIMER_MAX;
    else if (strobes.timerClear) timer <= '0;
    else if (strobes.timerStep)  timer <= timer + TIMER_ONE;
  end

  // Output register with enable
  always_ff @(posedge clk) begin
    if (rst)                 cleanOut <= RESET_LEVEL;
    else if (strobes.outLoad) cleanOut <= syncB;
  end

  always_ff @(posedge clk) pastValid <= !rst;

  // R1: second stage follows first stage by one clock
  p_sync_chain_r1: assert property (@(posedge clk) disable iff (rst || !pastValid)
    syncB == $past(syncA));

  // R2: a sampled transition zeroes the timer on the next edge
  p_clear_on_change_r2: assert property (@(posedge clk) disable iff (rst || !pastValid)
    sampleChange |=> timer == '0);

  // R3: steady input, timer below ceiling, advances by one
  p_count_up_r3: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (!sampleChange && !timerFull) |=> timer == TIMER_W'($past(timer) + TIMER_ONE));

  // R3: saturated timer stays saturated while input is steady
  p_hold_full_r3: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (timerFull && !sampleChange) |=> timerFull);

  // R4: output frozen unless timer was at its ceiling
  p_out_frozen_r4: assert property (@(posedge clk) disable iff (rst || !pastValid)
    !timerFull |=> $stable(cleanOut));

  // R4: at the ceiling the output takes the second-stage sample
  p_out_load_r4: assert property (@(posedge clk) disable iff (rst || !pastValid)
    timerFull |=> cleanOut == $past(syncB));

endmodule

// File: rtl/debounce_filter.sv
`timescale 1ns/1ps
module debounce_filter
  import dbn_pkg::*;
#(
  parameter int   TIMER_W     = 16,
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut
);

  dbnStrobes_t strobes;
  logic        sampleChange;
  logic        timerFull;

  dbn_control u_control (
    .sampleChange (sampleChange),
    .timerFull    (timerFull),
    .strobes      (strobes)
  );

  dbn_datapath #(
    .TIMER_W     (TIMER_W),
    .RESET_LEVEL (RESET_LEVEL)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .rawIn        (rawIn),
    .strobes      (strobes),
    .sampleChange (sampleChange),
    .timerFull    (timerFull),
    .cleanOut     (cleanOut)
  );

endmodule

// File: tb/tb_debounce_filter.sv
`timescale 1ns/1ps
module tb_debounce_filter;

  localparam int TW      = 4;
  localparam int M       = (1 << TW) - 1;   // 15
  localparam int WINDOW  = M + 3;           // edges until output follows
  localparam int N_VEC   = 14;

  // level applied, edges held, expected output afterwards
  localparam int VEC_LVL [N_VEC] = '{1, 0, 1, 0,  1, 1, 0,  1,  0, 1, 1,  1, 1,  1};
  localparam int VEC_CYC [N_VEC] = '{3, 2, 1, 20, 17, 1, 15, 25, 16, 1, 1, 15, 1, 30};
  localparam int VEC_EXP [N_VEC] = '{0, 0, 0, 0,  0, 1, 1,  1,  1, 1, 0,  0, 1,  1};
  localparam int VEC_REQ [N_VEC] = '{5, 5, 5, 3,  1, 1, 5,  5,  6, 6, 6,  2, 4,  3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rawIn = 1'b0;
  logic cleanOut;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  debounce_filter #(.TIMER_W(TW), .RESET_LEVEL(1'b0)) dut (
    .clk      (clk),
    .rst      (rst),
    .rawIn    (rawIn),
    .cleanOut (cleanOut)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s cleanOut=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string reqName(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R?";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(cleanOut, 1'b0, "R7 reset level");
    rst = 1'b0;

    // Table walk: inputs change and outputs are sampled at falling edges
    for (int i = 0; i < N_VEC; i++) begin
      rawIn = VEC_LVL[i][0];
      repeat (VEC_CYC[i]) @(negedge clk);
      check(cleanOut, VEC_EXP[i][0], reqName(VEC_REQ[i]));
    end

    // R7: reset in mid-run forces the output back at the edge
    rst = 1'b1;
    @(negedge clk);
    check(cleanOut, 1'b0, "R7 reset during run");

    // R8: input high at reset release needs the full window
    rst = 1'b0;
    repeat (WINDOW - 1) @(negedge clk);
    check(cleanOut, 1'b0, "R8 before window");
    @(negedge clk);
    check(cleanOut, 1'b1, "R8 at window");

    // R5: burst of short glitches toward low never moves the output
    for (int b = 0; b < 6; b++) begin
      rawIn = 1'b0;
      repeat (1 + b) @(negedge clk);
      rawIn = 1'b1;
      repeat (2) @(negedge clk);
      check(cleanOut, 1'b1, "R5 glitch burst");
    end

    // R1: full held drop to low after the burst
    rawIn = 1'b0;
    repeat (WINDOW - 1) @(negedge clk);
    check(cleanOut, 1'b1, "R1 one edge early");
    @(negedge clk);
    check(cleanOut, 1'b0, "R1 exact edge");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired cleanOut=%0b expected=done", cleanOut);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule